// File: doc/BRIEF.md
# Dual-Bank Memory Controller with Interlocked, Overlapped and Interleaved Modes

This block serves a single request bus with two storage banks. Each bank runs a long cycle: an access phase, in which the word is read or written, then a restore phase, during which the bank is unavailable. The controller maps each word address to one bank and times each bank with its own down-counter. It signals completion at the end of the access phase. It then frees the bus so that the other bank can take the next request while the first bank is still restoring.

A static mode input picks the address mapping and the release policy. In interlocked mode (0) every request waits until both banks have finished restoring. In overlapped mode (1) each bank holds one contiguous half of the address space. In interleaved mode (2) the lowest word-address bit picks the bank. A requester raises `req` with `we`, `addr` and `wdata`, holds them until `done` pulses, and may present the next request at once.

Top module: `dual_bank_mem`

## Requirements
- R1: While reset is held and after it, `done` is 0 and `rdata` is 0 until the first request completes.
- R2: In modes 0 and 1 (and the unused code 3), word addresses with the top address bit clear go to bank 0 and those with it set go to bank 1.
- R3: In mode 2, word addresses with bit 0 clear go to bank 0 and those with bit 0 set go to bank 1.
- R4: A request is accepted on the first rising edge at which it is allowed. `done` rises ACC_CYC rising edges after that edge and lasts exactly one cycle.
- R5: When `done` is high, `rdata` holds the stored word at the requested address. For a write, `wdata` is stored at acceptance, so `rdata` shows the new value.
- R6: Once a bank is accepted, it cannot accept again until ACC_CYC+RST_CYC rising edges later. Same-bank back-to-back requests are therefore spaced by the full bank cycle.
- R7: In modes 1 and 2, a request to the other bank, presented right after `done`, is accepted on the very next rising edge.
- R8: In mode 0, a request is accepted no earlier than ACC_CYC+RST_CYC edges after the last acceptance of either bank.
- R9: A request held off by a busy bank gets no `done` until it is accepted.
- R10: `mode` changes only while both banks are idle. A request right after a mode change is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 interlocked, 1 overlapped, 2 interleaved |
| req | input | 1 | Request, held until `done` |
| we | input | 1 | 1 write, 0 read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Word at the completed address |
| done | output | 1 | One-cycle completion pulse |

## Verification
In every mode the full address space is first written and then read back in four orders:
- ascending, which alternates banks only in the interleaved mapping;
- alternating halves, which alternates banks only in the contiguous mapping;
- stride two, which stays on one bank under interleaving;
- a scattered stride-seven order.

An arithmetic model predicts each acceptance edge from the last acceptance of each bank. Comparing every completion cycle with that prediction therefore separates the two decodes, the fast alternate-bank release, the full-cycle same-bank stall and the interlocked wait. The read data checks that the mapping stores and returns each word without aliasing.

// File: rtl/dual_bank_mem.sv
module dual_bank_mem #(
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int ACC_CYC = 4,
  parameter int RST_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done
);
  localparam int TOT  = ACC_CYC + RST_CYC;
  localparam int CW   = $clog2(TOT + 1);
  localparam int HALF = 1 << (AW - 1);
  localparam logic [1:0] M_LOCK = 2'd0;
  localparam logic [1:0] M_ILV  = 2'd2;
  localparam logic [CW-1:0] C_TOT  = CW'(TOT);
  localparam logic [CW-1:0] C_RST  = CW'(RST_CYC);
  localparam logic [CW-1:0] C_LAST = CW'(RST_CYC + 1);

  logic [CW-1:0] cnt0, cnt1;
  logic [DW-1:0] mem [2][HALF];
  logic          cur_bank;
  logic [AW-2:0] cur_idx;

  wire          sel   = (mode == M_ILV) ? addr[0] : addr[AW-1];
  wire [AW-2:0] idx   = (mode == M_ILV) ? addr[AW-1:1] : addr[AW-2:0];
  wire          free0 = cnt0 <= CW'(1);
  wire          free1 = cnt1 <= CW'(1);
  wire          acc0  = cnt0 > C_RST;
  wire          acc1  = cnt1 > C_RST;
  wire          bank_ok = (mode == M_LOCK) ? (free0 && free1) : (sel ? free1 : free0);
  wire          start = req && !(acc0 || acc1) && bank_ok;
  wire [CW-1:0] cur_cnt = cur_bank ? cnt1 : cnt0;
  wire          finish = cur_cnt == C_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt0     <= '0;
      cnt1     <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      cur_bank <= 1'b0;
      cur_idx  <= '0;
    end else begin
      if (start && !sel)   cnt0 <= C_TOT;
      else if (cnt0 != 0)  cnt0 <= cnt0 - CW'(1);
      if (start && sel)    cnt1 <= C_TOT;
      else if (cnt1 != 0)  cnt1 <= cnt1 - CW'(1);
      if (start) begin
        cur_bank <= sel;
        cur_idx  <= idx;
      end
      done <= finish;
      if (finish) rdata <= mem[cur_bank][cur_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && start && we) mem[sel][idx] <= wdata;
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_restore_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 > CW'(1)) |=> (cnt0 == $past(cnt0) - CW'(1)));

  p_restore_hold1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt1 > CW'(1)) |=> (cnt1 == $past(cnt1) - CW'(1)));

  p_single_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc0 && acc1));

  p_interlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOCK) |-> (cnt0 == 0 || cnt1 == 0));

  p_mode_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 != 0 || cnt1 != 0) |=> $stable(mode));
endmodule

// File: tb/dual_bank_mem_test.sv
module dual_bank_mem_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int ACC = 4;
  localparam int RST = 4;
  localparam int TOT = ACC + RST;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_acc [2];
  logic [DW-1:0] model [NW];

  dual_bank_mem #(.AW(AW), .DW(DW), .ACC_CYC(ACC), .RST_CYC(RST)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bank_of(input int m, input int a);
    return (m == 2) ? (a & 1) : ((a >> (AW - 1)) & 1);
  endfunction

  task automatic op(input bit w, input int a, input logic [DW-1:0] d);
    int b, o, acc, exp_done, waited;
    string tag;
    bit conflict;
    b = bank_of(mode, a);
    o = 1 - b;
    acc = cyc + 1;
    conflict = 1'b0;
    if (last_acc[b] + TOT > acc) begin acc = last_acc[b] + TOT; conflict = 1'b1; end
    if (mode == 0 && last_acc[o] + TOT > acc) begin acc = last_acc[o] + TOT; conflict = 1'b1; end
    exp_done = acc + ACC;
    if (conflict) tag = (mode == 0) ? "R8" : "R6";
    else tag = (mode == 2) ? "R3 R7 R4" : "R2 R7 R4";
    req = 1'b1; we = w; addr = AW'(a); wdata = d;
    waited = 0;
    forever begin
      @(negedge clk);
      waited++;
      if (done) break;
      if (waited > 64) break;
    end
    if (done && cyc < exp_done) check(1'b0, "R9 early done", cyc, exp_done);
    check(done && cyc == exp_done, tag, cyc, exp_done);
    if (w) model[a] = d;
    check(rdata == model[a], "R5 data", int'(rdata), int'(model[a]));
    last_acc[b] = acc;
    req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    last_acc[0] = -1000;
    last_acc[1] = -1000;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(rdata == '0, "R1 rdata in reset", int'(rdata), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1 done idle", int'(done), 0);
    check(rdata == '0, "R1 rdata idle", int'(rdata), 0);

    for (int m = 0; m < 3; m++) begin
      repeat (2 * TOT) @(negedge clk);
      mode = 2'(m);
      // R10: mode changed with both banks idle; first op must be fast
      begin
        int t0;
        t0 = cyc;
        op(1'b1, 0, 16'(m * 1000 + 5));
        check(cyc == t0 + 1 + ACC, "R10 after mode change", cyc, t0 + 1 + ACC);
      end
      for (int a = 1; a < NW; a++) op(1'b1, a, 16'(a * 37 + m * 1000 + 5));
      for (int a = 0; a < NW; a++) op(1'b0, a, '0);
      for (int i = 0; i < NW; i++) op(1'b0, (i / 2) + (i % 2) * (NW / 2), '0);
      for (int i = 0; i < NW; i++) op(1'b0, (2 * i) % NW + (2 * i) / NW, '0);
      for (int i = 0; i < NW; i++) op(1'b0, (7 * i) % NW, '0);
      for (int i = 0; i < 8; i++) op(1'b1, (5 * i + 3) % NW, 16'(i * 911 + m));
      for (int i = 0; i < 8; i++) op(1'b0, (5 * i + 3) % NW, '0);
    end

    repeat (4) @(negedge clk);
    check(done == 1'b0, "R4 no stray done", int'(done), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule